// File: doc/BRIEF.md
# Credit-Throttled Synchronous FIFO

This block is a single-clock first-in first-out buffer whose writer is held back by a credit counter rather than by a full flag. At reset the writer holds one credit for every storage slot. Each request the buffer takes spends one credit, and each entry the consumer drains gives one back. The writer may only push while it holds a credit. Because of this, the storage can never be asked to take more entries than it has, and no pointer comparison for fullness is needed.

The writer sees a credit-available output and the live credit level. The consumer sees a not-empty flag. It issues a read enable and receives registered data, together with a one-cycle valid strobe, on the following cycle. Reset is asynchronous and active-low. It empties the buffer and returns the full credit pool.

Top module: `credit_fifo`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `credit_level` equals DEPTH, `credit_ok` is 1, `not_empty` is 0 and `rd_valid` is 0. Asserting `rst_n` low mid-run restores this state without waiting for a clock edge.
- R2: A request is taken when `req_valid` is 1 and `credit_ok` is 1. A taken request with no read in the same cycle lowers `credit_level` by exactly one at the next edge.
- R3: A read is taken when `rd_en` is 1 and `not_empty` is 1. A taken read with no request in the same cycle raises `credit_level` by exactly one at the next edge.
- R4: A taken request and a taken read in the same cycle leave `credit_level` unchanged.
- R5: `credit_ok` is 0 exactly when `credit_level` is 0. A request presented in that state is dropped: the credit level stays 0 and the data never appears on the read side.
- R6: `credit_level` never exceeds DEPTH.
- R7: After a taken read, `rd_valid` is 1 for exactly the following cycle, and `rd_data` then carries the oldest stored entry. Entries leave in the order they were taken.
- R8: `rd_en` while `not_empty` is 0 is ignored. `rd_valid` stays 0 and `credit_level` is unchanged. This holds even when a request is taken in the same cycle.
- R9: `not_empty` is 1 exactly when `credit_level` is below DEPTH.
- R10: Order is kept when the internal write and read positions wrap past the last slot, over repeated fill and drain rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Writer presents a request |
| req_data | input | DATA_W | Request payload |
| credit_ok | output | 1 | At least one credit held; a request will be taken |
| credit_level | output | $clog2(DEPTH+1) | Credits currently held by the writer |
| rd_en | input | 1 | Consumer asks for one entry |
| not_empty | output | 1 | At least one entry is stored |
| rd_valid | output | 1 | `rd_data` carries a freshly read entry |
| rd_data | output | DATA_W | Registered read payload |

## Verification
The hardest case to reach from the ports is a request that arrives while the credit pool is exhausted, in the same cycle as a read that frees a credit. The credit is only returned at the edge, so this request must still be dropped. The stimulus table fills the buffer to zero credits and presents one lone request in that state. It then presents a second request together with a read. Draining the buffer afterwards shows that neither dropped payload ever comes out. A later vector pushes and reads together into an empty buffer, which checks that the read is not taken. Directed fill and drain rounds then drive both positions around the slot range several times.

// File: rtl/credit_fifo_pkg.sv
package credit_fifo_pkg;

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/credit_fifo_ctr.sv
module credit_fifo_ctr #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_req,
   input  logic             take_rd,
   output logic [CNT_W-1:0] level,
   output logic             has_credit,
   output logic             holds_entry
);

   localparam logic [CNT_W-1:0] FULL_POOL = CNT_W'(DEPTH);

   logic [CNT_W-1:0] level_q;
   logic [CNT_W-1:0] level_d;

   always_comb begin
      level_d = level_q;
      unique case ({take_req, take_rd})
         2'b10:   level_d = level_q - 1'b1;
         2'b01:   level_d = level_q + 1'b1;
         default: level_d = level_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= FULL_POOL;
      else        level_q <= level_d;
   end

   assign level       = level_q;
   assign has_credit  = (level_q != '0);
   assign holds_entry = (level_q != FULL_POOL);

endmodule

// File: rtl/credit_fifo_ptr.sv
module credit_fifo_ptr #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned PTR_W = credit_fifo_pkg::idx_width(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [PTR_W-1:0] ptr_q;

   generate
      if (credit_fifo_pkg::is_pow2(DEPTH)) begin : g_natural_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr_q <= '0;
            else if (adv) ptr_q <= ptr_q + 1'b1;
         end
      end else begin : g_compare_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr_q <= '0;
            else if (adv) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
         end
      end
   endgenerate

   assign ptr = ptr_q;

endmodule

// File: rtl/credit_fifo_mem.sv
module credit_fifo_mem #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PTR_W  = credit_fifo_pkg::idx_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [PTR_W-1:0]  wr_at,
   input  logic [DATA_W-1:0] wr_val,
   input  logic              rd_go,
   input  logic [PTR_W-1:0]  rd_at,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_val
);

   logic [DATA_W-1:0] slot [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_go) slot[wr_at] <= wr_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_val   <= '0;
      end else begin
         out_valid <= rd_go;
         if (rd_go) out_val <= slot[rd_at];
      end
   end

endmodule

// File: rtl/credit_fifo.sv
module credit_fifo #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = credit_fifo_pkg::idx_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] req_data,
   output logic              credit_ok,
   output logic [CNT_W-1:0]  credit_level,
   input  logic              rd_en,
   output logic              not_empty,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("credit_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("credit_fifo: DATA_W must be at least 1");
      end
   endgenerate

   logic             take_req;
   logic             take_rd;
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;

   assign take_req = req_valid & credit_ok;
   assign take_rd  = rd_en & not_empty;

   credit_fifo_ctr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_req    (take_req),
      .take_rd     (take_rd),
      .level       (credit_level),
      .has_credit  (credit_ok),
      .holds_entry (not_empty)
   );

   credit_fifo_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (take_req),
      .ptr   (wr_ptr)
   );

   credit_fifo_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (take_rd),
      .ptr   (rd_ptr)
   );

   credit_fifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_go     (take_req),
      .wr_at     (wr_ptr),
      .wr_val    (req_data),
      .rd_go     (take_rd),
      .rd_at     (rd_ptr),
      .out_valid (rd_valid),
      .out_val   (rd_data)
   );

endmodule

// File: rtl/credit_fifo_chk.sv
module credit_fifo_chk #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             credit_ok,
   input logic [CNT_W-1:0] credit_level,
   input logic             rd_en,
   input logic             not_empty,
   input logic             rd_valid
);

   logic acc_w;
   logic acc_r;
   assign acc_w = req_valid && credit_ok;
   assign acc_r = rd_en && not_empty;

   AST_CREDIT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_w && !acc_r) |=> (credit_level == $past(credit_level) - 1'b1)); // R2
   AST_CREDIT_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_r && !acc_w) |=> (credit_level == $past(credit_level) + 1'b1)); // R3
   AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_w && acc_r) |=> $stable(credit_level)); // R4
   AST_ZERO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && credit_level == '0 && !acc_r) |=> (credit_level == '0)); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      credit_level <= CNT_W'(DEPTH)); // R6
   AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_r |=> rd_valid); // R7
   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !not_empty) |=> !rd_valid); // R8

endmodule

bind credit_fifo credit_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .credit_ok    (credit_ok),
   .credit_level (credit_level),
   .rd_en        (rd_en),
   .not_empty    (not_empty),
   .rd_valid     (rd_valid)
);

// File: tb/sim_credit_fifo.sv
`timescale 1ns/1ps
module sim_credit_fifo;

   localparam int DEPTH  = 4;
   localparam int DATA_W = 8;
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int NV     = 15;

   // entry: {req_valid, req_data[8], rd_en, exp_credit[3], exp_rd_valid, exp_rd_data[8]}
   localparam logic [21:0] VEC [NV] = '{
      {1'b1, 8'hA1, 1'b0, 3'd3, 1'b0, 8'h00},  // R2 push
      {1'b1, 8'hB2, 1'b0, 3'd2, 1'b0, 8'h00},  // R2 push
      {1'b1, 8'hC3, 1'b1, 3'd2, 1'b1, 8'hA1},  // R4 push+read
      {1'b0, 8'h00, 1'b1, 3'd3, 1'b1, 8'hB2},  // R3 read
      {1'b1, 8'hD4, 1'b0, 3'd2, 1'b0, 8'h00},
      {1'b1, 8'hE5, 1'b0, 3'd1, 1'b0, 8'h00},
      {1'b1, 8'hF6, 1'b0, 3'd0, 1'b0, 8'h00},  // pool exhausted
      {1'b1, 8'h77, 1'b0, 3'd0, 1'b0, 8'h00},  // R5 dropped
      {1'b1, 8'h88, 1'b1, 3'd1, 1'b1, 8'hC3},  // R5 dropped while read frees one
      {1'b0, 8'h00, 1'b1, 3'd2, 1'b1, 8'hD4},
      {1'b0, 8'h00, 1'b1, 3'd3, 1'b1, 8'hE5},
      {1'b0, 8'h00, 1'b1, 3'd4, 1'b1, 8'hF6},  // R7 order, no 77/88
      {1'b0, 8'h00, 1'b1, 3'd4, 1'b0, 8'h00},  // R8 empty read
      {1'b1, 8'h99, 1'b1, 3'd3, 1'b0, 8'h00},  // R8 read ignored, push taken
      {1'b0, 8'h00, 1'b1, 3'd4, 1'b1, 8'h99}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [DATA_W-1:0] req_data = '0;
   logic              credit_ok;
   logic [CNT_W-1:0]  credit_level;
   logic              rd_en = 1'b0;
   logic              not_empty;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   credit_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic rv, input logic [7:0] d, input logic re);
      @(negedge clk);
      req_valid = rv;
      req_data  = d;
      rd_en     = re;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(credit_level == 3'(DEPTH), "R1 credit during reset", credit_level, DEPTH);
      chk(credit_ok && !not_empty && !rd_valid, "R1 flags during reset",
          {credit_ok, not_empty, rd_valid}, 3'b100);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(credit_level == 3'(DEPTH), "R1 credit after release", credit_level, DEPTH);

      for (int i = 0; i < NV; i++) begin
         logic [21:0] v;
         v = VEC[i];
         step(v[21], v[20:13], v[12]);
         chk(credit_level == v[11:9], $sformatf("R2 R3 R4 R5 credit vec %0d", i),
             credit_level, v[11:9]);
         chk(credit_ok == (v[11:9] != 0), $sformatf("R5 credit_ok vec %0d", i),
             credit_ok, (v[11:9] != 0));
         chk(not_empty == (v[11:9] != 3'(DEPTH)), $sformatf("R9 not_empty vec %0d", i),
             not_empty, (v[11:9] != 3'(DEPTH)));
         chk(rd_valid == v[8], $sformatf("R7 R8 rd_valid vec %0d", i), rd_valid, v[8]);
         if (v[8])
            chk(rd_data == v[7:0], $sformatf("R7 rd_data vec %0d", i), rd_data, v[7:0]);
      end

      // R10: repeated fill/drain rounds drive both positions through wrap
      for (int r = 0; r < 3; r++) begin
         for (int k = 0; k < DEPTH; k++) step(1'b1, 8'(8'h10 * r + k + 1), 1'b0);
         chk(!credit_ok && credit_level == 0, $sformatf("R5 full round %0d", r),
             credit_level, 0);
         for (int k = 0; k < DEPTH; k++) begin
            step(1'b0, 8'h00, 1'b1);
            chk(rd_valid && rd_data == 8'(8'h10 * r + k + 1),
                $sformatf("R10 order round %0d slot %0d", r, k), rd_data,
                8'(8'h10 * r + k + 1));
         end
         step(1'b0, 8'h00, 1'b0);
         chk(!rd_valid, $sformatf("R7 strobe one cycle round %0d", r), rd_valid, 0);
         chk(credit_level <= 3'(DEPTH) && !not_empty, $sformatf("R6 R9 drained round %0d", r),
             credit_level, DEPTH);
      end

      // R1: asynchronous reset mid-run
      step(1'b1, 8'h5A, 1'b0);
      step(1'b1, 8'h5B, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      #3;
      rst_n = 1'b0;
      #1;
      chk(credit_level == 3'(DEPTH) && !not_empty, "R1 async reset", credit_level, DEPTH);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 8'h00, 1'b1);
      chk(!rd_valid, "R8 read after reset ignored", rd_valid, 0);

      finish_run();
   end

endmodule